// File: doc/BRIEF.md
# Acquisition Buffer Write Pointer and Interrupt Controller

This block steers conversion results into a 128K-word by 16-bit acquisition buffer and reports progress to the host bus through an interrupt. A sequencer sends a strobe for every conversion word and a pulse at every end of scan. For each strobe accepted while acquisition runs, the block issues a memory write enable together with the buffer address, then advances a 20-bit conversion pointer. Software reads and writes that pointer through a 16-bit low half and a 4-bit high half.

Two buffer policies are available. In the continuous policy the pointer returns to zero after the last word. In the halting policy acquisition stops on the last word until the arm input is raised again. A down-counter loaded from a 16-bit preset counts end-of-scan pulses and sets a sticky scan-complete flag. Filling the last word sets a sticky buffer-full flag. Either event, when interrupts are enabled, raises an interrupt request. That request is held until an acknowledge cycle presents the programmed 3-bit level, and the acknowledge returns the programmed 16-bit vector.

Top module: `acq_ptr_irq`

## Requirements
- R1: After reset, both pointer halves read 0, and `acquiring`, `scan_done`, `mem_full`, `irq_req` and `iack_valid` are 0.
- R2: `ptr_lo_wr` loads `wdata` into pointer bits 15:0. `ptr_hi_wr` loads `wdata[3:0]` into pointer bits 19:16, and `ptr_hi_q` reads 0 in bits 15:4. Both take effect on the next clock, and a software write overrides the increment in the same cycle.
- R3: While `acquiring` is 1, each cycle with `conv_stb` high asserts `mem_we` in that cycle, with `mem_addr` equal to pointer bits 16:0. The pointer then advances by one on the next clock.
- R4: `acquiring` equals `arm` and not halted. While `acquiring` is 0, `conv_stb` produces no `mem_we` and leaves the pointer unchanged.
- R5: With `wrap_en` at 1, a write at address 0x1FFFF sets the pointer to 0 and sets `mem_full`, and `acquiring` stays 1.
- R6: With `wrap_en` at 0, a write at address 0x1FFFF still takes place. The pointer then holds at 0x1FFFF, `mem_full` sets, and `acquiring` drops. Later strobes are ignored until `arm` goes low and rises again, which clears the halt.
- R7: The scan counter loads `scan_preset` on a rising edge of `arm` and after each scan-complete event. Each `eos` while acquiring counts down, and the preset-th `eos` sets `scan_done`. A preset of 0 behaves as 1.
- R8: `scan_done` and `mem_full` stay set until `done_clr` or `full_clr` respectively. If a new event and the clear arrive in the same cycle, the event wins.
- R9: A scan-complete or buffer-full event raises `irq_req` on the next clock only when `irq_en` is 1. `irq_req` then stays high until a matching acknowledge.
- R10: An `iack` with `iack_level` equal to `irq_level` while `irq_req` is 1 clears `irq_req` on the next clock. In that same clock it pulses `iack_valid` for one cycle with `iack_vector` equal to `irq_vector`. An `iack` with any other level changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Acquisition enable level; a rising edge restarts |
| wrap_en | input | 1 | 1: continuous (wrap to zero), 0: halt when full |
| irq_en | input | 1 | Interrupt enable |
| irq_level | input | 3 | Interrupt priority level |
| irq_vector | input | 16 | Vector returned on acknowledge |
| scan_preset | input | 16 | Scans per scan-complete event |
| wdata | input | 16 | Software write data for the pointer halves |
| ptr_lo_wr | input | 1 | Write strobe, pointer low half |
| ptr_hi_wr | input | 1 | Write strobe, pointer high half |
| ptr_lo_q | output | 16 | Pointer bits 15:0 |
| ptr_hi_q | output | 16 | Pointer bits 19:16, zero-extended |
| conv_stb | input | 1 | One conversion word ready |
| eos | input | 1 | End-of-scan pulse |
| mem_we | output | 1 | Buffer write enable |
| mem_addr | output | 17 | Buffer write address |
| acquiring | output | 1 | Acquisition active |
| done_clr | input | 1 | Clear scan_done |
| full_clr | input | 1 | Clear mem_full |
| scan_done | output | 1 | Sticky scan-complete flag |
| mem_full | output | 1 | Sticky buffer-full flag |
| irq_req | output | 1 | Interrupt request |
| iack | input | 1 | Interrupt acknowledge cycle |
| iack_level | input | 3 | Level presented by the acknowledge |
| iack_valid | output | 1 | Vector valid, one cycle |
| iack_vector | output | 16 | Returned vector |

## Verification
Some properties are checked on every cycle. A pointer outside acquisition only moves on a software write. Continuous mode lands on zero after the last word. The full flag rises only after a write to the last address. A request never appears while interrupts were disabled, a matching acknowledge always drops the request, and a vector is only returned after a live request. Other behaviours need the bench's scenarios: the exact address sequence across both buffer policies, the count of scans to the scan-complete flag (including a preset of zero), the release of a halt by re-arming, and the ignoring of a mismatched acknowledge level.

// File: rtl/acq_ptr_irq.sv
module acq_ptr_irq #(
  parameter int PTR_W  = 20,
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 16,
  parameter int VEC_W  = 16,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              wrap_en,
  input  logic              irq_en,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic [VEC_W-1:0]  irq_vector,
  input  logic [CNT_W-1:0]  scan_preset,
  input  logic [15:0]       wdata,
  input  logic              ptr_lo_wr,
  input  logic              ptr_hi_wr,
  output logic [15:0]       ptr_lo_q,
  output logic [15:0]       ptr_hi_q,
  input  logic              conv_stb,
  input  logic              eos,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              acquiring,
  input  logic              done_clr,
  input  logic              full_clr,
  output logic              scan_done,
  output logic              mem_full,
  output logic              irq_req,
  input  logic              iack,
  input  logic [LVL_W-1:0]  iack_level,
  output logic              iack_valid,
  output logic [VEC_W-1:0]  iack_vector
);
  localparam int HI_W = PTR_W - 16;
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic [PTR_W-1:0] ptr;
  logic [CNT_W-1:0] cnt;
  logic halted, arm_d, pend;

  wire unused_ok = &{1'b0, wdata[15:HI_W]};
  wire arm_rise  = arm & ~arm_d;
  wire at_last   = mem_addr == LAST;
  wire full_evt  = mem_we & at_last;
  wire done_evt  = eos & acquiring & (cnt <= CNT_W'(1));
  wire ack_hit   = pend & iack & (iack_level == irq_level);
  wire sw_wr     = ptr_lo_wr | ptr_hi_wr;

  assign acquiring = arm & ~halted;
  assign mem_we    = conv_stb & acquiring;
  assign mem_addr  = ptr[ADDR_W-1:0];
  assign ptr_lo_q  = ptr[15:0];
  assign ptr_hi_q  = {{(16-HI_W){1'b0}}, ptr[PTR_W-1:16]};
  assign irq_req   = pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else begin
      if (mem_we) begin
        if (!at_last)     ptr <= ptr + PTR_W'(1);
        else if (wrap_en) ptr <= '0;
      end
      if (ptr_lo_wr) ptr[15:0]       <= wdata;
      if (ptr_hi_wr) ptr[PTR_W-1:16] <= wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted <= 1'b0;
      arm_d  <= 1'b0;
      cnt    <= '0;
    end else begin
      arm_d <= arm;
      if (arm_rise)                   halted <= 1'b0;
      else if (full_evt && !wrap_en)  halted <= 1'b1;
      if (arm_rise || done_evt)       cnt <= scan_preset;
      else if (eos && acquiring)      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_done   <= 1'b0;
      mem_full    <= 1'b0;
      pend        <= 1'b0;
      iack_valid  <= 1'b0;
      iack_vector <= '0;
    end else begin
      if (done_evt)      scan_done <= 1'b1;
      else if (done_clr) scan_done <= 1'b0;
      if (full_evt)      mem_full <= 1'b1;
      else if (full_clr) mem_full <= 1'b0;
      if (ack_hit)                                pend <= 1'b0;
      else if (irq_en && (done_evt || full_evt))  pend <= 1'b1;
      iack_valid <= ack_hit;
      if (ack_hit) iack_vector <= irq_vector;
    end
  end

  // R4
  ptr_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acquiring && !sw_wr) |=> $stable(ptr));
  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == LAST && wrap_en && !sw_wr) |=> (ptr == '0));
  // R6
  full_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_full) |-> ($past(mem_we) && $past(mem_addr) == LAST));
  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(irq_en));
  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && iack && iack_level == irq_level) |=> (!irq_req && iack_valid));
  // R10
  vec_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iack_valid |-> $past(irq_req));
endmodule

// File: tb/sim_acq_ptr_irq.sv
`timescale 1ns/1ps
module sim_acq_ptr_irq;
  logic clk = 0, rst_n = 0;
  logic arm = 0, wrap_en = 0, irq_en = 0;
  logic [2:0] irq_level = 3'd5, iack_level = 3'd0;
  logic [15:0] irq_vector = 16'hA5C3, scan_preset = 16'd3, wdata = 0;
  logic ptr_lo_wr = 0, ptr_hi_wr = 0, conv_stb = 0, eos = 0;
  logic done_clr = 0, full_clr = 0, iack = 0;
  logic [15:0] ptr_lo_q, ptr_hi_q, iack_vector;
  logic mem_we, acquiring, scan_done, mem_full, irq_req, iack_valid;
  logic [16:0] mem_addr;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [16:0] exp_q[$];

  always #2.5 clk = ~clk;

  acq_ptr_irq u0 (.clk, .rst_n, .arm, .wrap_en, .irq_en, .irq_level, .irq_vector,
    .scan_preset, .wdata, .ptr_lo_wr, .ptr_hi_wr, .ptr_lo_q, .ptr_hi_q, .conv_stb,
    .eos, .mem_we, .mem_addr, .acquiring, .done_clr, .full_clr, .scan_done,
    .mem_full, .irq_req, .iack, .iack_level, .iack_valid, .iack_vector);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic set_ptr(logic [19:0] v);
    wdata = v[15:0]; ptr_lo_wr = 1; tick(); ptr_lo_wr = 0;
    wdata = {12'd0, v[19:16]}; ptr_hi_wr = 1; tick(); ptr_hi_wr = 0;
  endtask

  // driver: one strobe, optionally pushing the expected write address
  task automatic strobe(bit expect_wr, logic [16:0] a);
    if (expect_wr) exp_q.push_back(a);
    conv_stb = 1; tick(); conv_stb = 0;
  endtask

  task automatic pulse_eos();
    eos = 1; tick(); eos = 0;
  endtask

  task automatic ack(logic [2:0] lvl);
    iack = 1; iack_level = lvl; tick(); iack = 0;
  endtask

  // monitor: compare each observed write with the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) chk("R4 unexpected write", {15'd0, mem_addr}, 32'hFFFFFFFF);
      else chk("R3 write address", {15'd0, mem_addr}, {15'd0, exp_q.pop_front()});
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #200000;
    chk("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    tick(); tick(); tick();
    rst_n = 1; tick();
    chk("R1 ptr_lo", ptr_lo_q, 0);
    chk("R1 ptr_hi", ptr_hi_q, 0);
    chk("R1 flags", {acquiring, scan_done, mem_full, irq_req, iack_valid}, 0);

    set_ptr(20'hF1234);
    chk("R2 ptr_lo", ptr_lo_q, 16'h1234);
    chk("R2 ptr_hi 4 bits", ptr_hi_q, 16'h000F);
    set_ptr(20'h00010);

    strobe(0, 0);
    chk("R4 ptr unchanged unarmed", ptr_lo_q, 16'h0010);
    chk("R4 not acquiring", acquiring, 0);

    irq_en = 1; arm = 1; tick();
    chk("R4 acquiring after arm", acquiring, 1);
    strobe(1, 17'h10); strobe(1, 17'h11); tick(); strobe(1, 17'h12);
    tick(); tick(); strobe(1, 17'h13);
    chk("R3 pointer advanced", ptr_lo_q, 16'h0014);

    // R2: software write overrides increment
    wdata = 16'h0100; ptr_lo_wr = 1; strobe(1, 17'h14); ptr_lo_wr = 0;
    chk("R2 sw write wins", ptr_lo_q, 16'h0100);

    pulse_eos(); pulse_eos();
    chk("R7 not done after 2 scans", scan_done, 0);
    pulse_eos();
    chk("R7 done after 3 scans", scan_done, 1);
    chk("R9 irq raised", irq_req, 1);

    ack(3'd2);
    chk("R10 mismatched level keeps req", irq_req, 1);
    chk("R10 mismatched no vector", iack_valid, 0);
    ack(3'd5);
    chk("R10 req cleared", irq_req, 0);
    chk("R10 valid", iack_valid, 1);
    chk("R10 vector", iack_vector, 16'hA5C3);
    tick();
    chk("R10 valid one cycle", iack_valid, 0);

    // R7 counter reloaded after event; R8 set wins over clear
    pulse_eos(); pulse_eos();
    done_clr = 1; pulse_eos(); done_clr = 0;
    chk("R8 set wins over clear", scan_done, 1);
    chk("R9 irq second event", irq_req, 1);
    done_clr = 1; tick(); done_clr = 0;
    chk("R8 done cleared", scan_done, 0);
    ack(3'd5);

    // R5 wrap mode
    wrap_en = 1; set_ptr(20'h1FFFE);
    strobe(1, 17'h1FFFE); strobe(1, 17'h1FFFF); strobe(1, 17'h00000);
    chk("R5 ptr wrapped", {ptr_hi_q, ptr_lo_q}, 32'h0000_0001);
    chk("R5 full set", mem_full, 1);
    chk("R5 still acquiring", acquiring, 1);
    chk("R9 irq on full", irq_req, 1);
    ack(3'd5);
    full_clr = 1; tick(); full_clr = 0;
    chk("R8 full cleared", mem_full, 0);

    // R6 stop mode, interrupts off
    wrap_en = 0; irq_en = 0; set_ptr(20'h1FFFE);
    strobe(1, 17'h1FFFE); strobe(1, 17'h1FFFF);
    chk("R6 acquiring dropped", acquiring, 0);
    strobe(0, 0);
    chk("R6 ptr holds at last", {ptr_hi_q, ptr_lo_q}, 32'h0001_FFFF);
    chk("R6 full set", mem_full, 1);
    chk("R9 no irq when disabled", irq_req, 0);

    arm = 0; tick(); arm = 1; tick();
    chk("R6 rearm resumes", acquiring, 1);
    strobe(1, 17'h1FFFF);
    chk("R6 halts again", acquiring, 0);

    // R7 preset of zero behaves as one
    scan_preset = 0; arm = 0; tick(); arm = 1; tick();
    pulse_eos();
    chk("R7 preset zero", scan_done, 1);

    tick(); tick();
    chk("R3 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule